// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Stall Controller

This block owns the occupancy bits and the advance enables of an in-order, single-issue pipeline with six stages. Stage index 0 is fetch, 1 is decode, 2 is execute, 3 is memory, 4 is align and 5 is writeback. Each stage holds one valid bit. Every cycle the controller decides, per stage, whether the stage loads from the stage before it, keeps what it has, or is loaded with an empty slot (a bubble). The datapath registers elsewhere in the core use the same enables, so their contents always line up with these valid bits.

Only two places can freeze the pipeline. The align stage requests a freeze when the instruction in it is still waiting on a data-bus transfer, or on a multicycle shifter or divider that the core was built with. The decode stage requests a freeze when its instruction depends on a long-latency result that is not yet ready. A freeze stops the requesting stage and every stage before it. Stages behind a freeze never move up into an empty slot ahead of them. A flush input drops the three youngest stages when the front end is redirected.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bit of `stage_valid` is cleared. The first cycle after reset shows all valid bits low, `stage_adv` all ones and `stage_bubble` all zeros.
- R2: With no freeze and no flush, each clock edge moves every valid bit up one stage (bit k takes bit k-1) and loads bit 0 from `issue_valid`. At most one instruction enters and one leaves per cycle, in program order.
- R3: An align freeze is raised when `stage_valid[4]` is high and at least one enabled align source is busy. During it `stage_adv[4:0]` are low and `stage_valid[4:0]` keep their values across the edge.
- R4: During an align freeze `stage_bubble[5]` is high, `stage_adv[5]` stays high and `stage_valid[5]` is low after the edge.
- R5: A decode freeze is raised when `stage_valid[1]` and `d_hazard` are high and no align freeze is present. During it `stage_adv[1:0]` are low and bits 1:0 keep their values. `stage_bubble[2]` is high and bit 2 is low after the edge, while bits 3 to 5 advance as in R2.
- R6: When both freezes are requested, the align freeze wins. Stages 0 to 4 hold, stage 2 gets no bubble, and `stage_bubble` is 6'b100000.
- R7: A frozen stage keeps its value even when the stage ahead of it is empty. No stage behind a freeze advances into a vacant slot.
- R8: With `HAS_SHIFT` = 0, `a_shift_busy` has no effect, and with `HAS_DIV` = 0, `a_div_busy` has no effect, on any output or on the next valid bits.
- R9: Align sources have no effect while `stage_valid[4]` is low. `d_hazard` has no effect while `stage_valid[1]` is low.
- R10: When `flush` is high at a clock edge, `stage_valid[2:0]` are cleared after that edge, even during a freeze. Bits 5:3 follow R2 to R6 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Drops fetch, decode and execute occupancy |
| issue_valid | input | 1 | A new instruction is offered to the fetch stage |
| a_mem_busy | input | 1 | Align-stage data-bus transfer still outstanding |
| a_shift_busy | input | 1 | Align-stage multicycle shift or rotate still running |
| a_div_busy | input | 1 | Align-stage divide still running |
| d_hazard | input | 1 | Decode-stage operand waits on a long-latency result |
| stage_valid | output | 6 | Occupancy per stage, bit 0 fetch to bit 5 writeback |
| stage_adv | output | 6 | Per-stage load enable for this cycle |
| stage_bubble | output | 6 | Per-stage empty-slot insertion for this cycle |

## Verification
The hardest cases to reach from the ports are those that need a particular occupancy pattern: a freeze while a gap sits directly ahead of a held stage, both freezes at once with decode and align both occupied, or a flush that lands during an align freeze. The bench reaches these by replaying every one of the 64 input combinations twice after priming a full pipeline. It then runs a long pseudo-random sequence with skewed probabilities, so that issue gaps and bursts of stalls produce every occupancy pattern. Two instances with opposite option settings receive the same stimulus, so a disabled source is exercised against a configuration where the same source is enabled.

// File: rtl/pstall_pkg.sv
// Package: stage indices and the occupancy vector type shared by the
// pipeline stall controller. Assumes a fixed six-stage ordering.
package pstall_pkg;
    localparam int NSTG = 6;
    localparam int ST_F = 0;
    localparam int ST_D = 1;
    localparam int ST_E = 2;
    localparam int ST_M = 3;
    localparam int ST_A = 4;
    localparam int ST_W = 5;
    typedef logic [NSTG-1:0] stg_vec_t;
endpackage

// File: rtl/stall_arbiter.sv
// Stall arbiter: turns align-stage busy sources and the decode hazard into
// per-stage hold and bubble controls. Assumes sources are only meaningful
// while the stage they describe is occupied; the align freeze outranks the
// decode freeze.
module stall_arbiter
    import pstall_pkg::*;
#(
    parameter int HAS_SHIFT = 1,
    parameter int HAS_DIV   = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  stg_vec_t occ,
    input  logic     a_mem_busy,
    input  logic     a_shift_busy,
    input  logic     a_div_busy,
    input  logic     d_hazard,
    output logic     a_freeze,
    output logic     d_freeze,
    output stg_vec_t hold,
    output stg_vec_t bubble
);
    localparam logic SH_EN = (HAS_SHIFT != 0);
    localparam logic DV_EN = (HAS_DIV != 0);

    logic a_src;

    // Purpose: merge the enabled align sources and rank the two freezes.
    always_comb begin
        a_src    = a_mem_busy | (SH_EN & a_shift_busy) | (DV_EN & a_div_busy);
        a_freeze = occ[ST_A] & a_src;
        d_freeze = occ[ST_D] & d_hazard & ~a_freeze;
    end

    // Purpose: a freeze holds its own stage and every stage before it.
    for (genvar k = 0; k < NSTG; k++) begin : g_hold
        if (k <= ST_D) begin : g_front
            assign hold[k] = a_freeze | d_freeze;
        end else if (k <= ST_A) begin : g_mid
            assign hold[k] = a_freeze;
        end else begin : g_tail
            assign hold[k] = 1'b0;
        end
    end

    // Purpose: place an empty slot just past each frozen region.
    for (genvar k = 0; k < NSTG; k++) begin : g_bub
        if (k == ST_W) begin : g_wb
            assign bubble[k] = a_freeze;
        end else if (k == ST_E) begin : g_ex
            assign bubble[k] = d_freeze;
        end else begin : g_none
            assign bubble[k] = 1'b0;
        end
    end

    // R6: the two freezes never appear together
    p_single_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_freeze && d_freeze));
    // R9: an empty align stage never raises a freeze
    p_empty_align_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !occ[ST_A] |-> !a_freeze);
endmodule

// File: rtl/stage_slot.sv
// Stage slot: one occupancy bit. Loads from the stage before it, holds,
// or takes a bubble. Assumes hold and bubble are never both high. Stages
// built with CAN_FLUSH are cleared by flush, which outranks hold.
module stage_slot #(
    parameter int CAN_FLUSH = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic hold,
    input  logic bubble,
    input  logic up_valid,
    output logic valid
);
    localparam logic FL_EN = (CAN_FLUSH != 0);

    // Purpose: update the occupancy bit by priority reset, flush, hold, bubble, load.
    always_ff @(posedge clk) begin
        if (!rst_n)               valid <= 1'b0;
        else if (FL_EN && flush)  valid <= 1'b0;
        else if (hold)            valid <= valid;
        else if (bubble)          valid <= 1'b0;
        else                      valid <= up_valid;
    end

    // R7: a held slot keeps its value whatever lies ahead of it
    p_hold_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !(FL_EN && flush) |=> $stable(valid));
    // R4: a bubble that is not held leaves the slot empty
    p_bubble_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bubble && !hold && !(FL_EN && flush) |=> !valid);
    // R10: flush empties a flushable slot
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        FL_EN && flush |=> !valid);
endmodule

// File: rtl/pipe_stall_ctrl.sv
// Pipeline stall controller top: one arbiter and six occupancy slots.
// Assumes in-order single issue; fetch is fed by issue_valid, and fetch,
// decode and execute are the flushable stages.
module pipe_stall_ctrl
    import pstall_pkg::*;
#(
    parameter int HAS_SHIFT = 1,
    parameter int HAS_DIV   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       issue_valid,
    input  logic       a_mem_busy,
    input  logic       a_shift_busy,
    input  logic       a_div_busy,
    input  logic       d_hazard,
    output logic [5:0] stage_valid,
    output logic [5:0] stage_adv,
    output logic [5:0] stage_bubble
);
    stg_vec_t occ, hold, bub, up_v;
    logic     a_freeze, d_freeze;

    stall_arbiter #(.HAS_SHIFT(HAS_SHIFT), .HAS_DIV(HAS_DIV)) u_arb (
        .clk(clk), .rst_n(rst_n), .occ(occ),
        .a_mem_busy(a_mem_busy), .a_shift_busy(a_shift_busy),
        .a_div_busy(a_div_busy), .d_hazard(d_hazard),
        .a_freeze(a_freeze), .d_freeze(d_freeze),
        .hold(hold), .bubble(bub)
    );

    // Purpose: chain the slots; fetch takes the issue request.
    for (genvar k = 0; k < NSTG; k++) begin : g_slot
        if (k == ST_F) begin : g_src
            assign up_v[k] = issue_valid;
        end else begin : g_chain
            assign up_v[k] = occ[k-1];
        end
        stage_slot #(.CAN_FLUSH(k <= ST_E ? 1 : 0)) u_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .hold(hold[k]), .bubble(bub[k]),
            .up_valid(up_v[k]), .valid(occ[k])
        );
    end

    // Purpose: present occupancy and per-stage controls.
    always_comb begin
        stage_valid  = occ;
        stage_adv    = ~hold;
        stage_bubble = bub;
    end

    // R2: with no freeze, writeback takes the align occupancy
    p_retire_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_freeze |=> stage_valid[ST_W] == $past(stage_valid[ST_A]));
    // R5: decode freeze lets memory drain from execute
    p_drain_behind_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        d_freeze |=> stage_valid[ST_M] == $past(stage_valid[ST_E]));
    // R6: with both requested, execute is held rather than bubbled
    p_align_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stage_valid[ST_A] && a_mem_busy && stage_valid[ST_D] && d_hazard
        |-> !stage_bubble[ST_E] && !stage_adv[ST_E]);
    // R3: an align freeze keeps memory occupancy in place
    p_align_holds_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        a_freeze |=> $stable(stage_valid[ST_M]));
endmodule

// File: tb/tb_pipe_stall_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_stall_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, issue_valid = 1'b0;
    logic a_mem_busy = 1'b0, a_shift_busy = 1'b0, a_div_busy = 1'b0, d_hazard = 1'b0;
    logic [5:0] va, adva, buba, vb, advb, bubb;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    // dut: shifter present, no divider; dut_b: the opposite options
    pipe_stall_ctrl #(.HAS_SHIFT(1), .HAS_DIV(0)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .issue_valid(issue_valid),
        .a_mem_busy(a_mem_busy), .a_shift_busy(a_shift_busy), .a_div_busy(a_div_busy),
        .d_hazard(d_hazard), .stage_valid(va), .stage_adv(adva), .stage_bubble(buba));
    pipe_stall_ctrl #(.HAS_SHIFT(0), .HAS_DIV(1)) dut_b (
        .clk(clk), .rst_n(rst_n), .flush(flush), .issue_valid(issue_valid),
        .a_mem_busy(a_mem_busy), .a_shift_busy(a_shift_busy), .a_div_busy(a_div_busy),
        .d_hazard(d_hazard), .stage_valid(vb), .stage_adv(advb), .stage_bubble(bubb));

    logic [5:0] exp_a = '0, exp_b = '0, pv_a = '0, pv_b = '0;
    logic [5:0] pin = '0;  // previous inputs {hz,dv,sh,mem,fl,iss}

    function automatic logic afrz(logic [5:0] v, logic [5:0] in, bit hs, bit hd);
        return v[4] & (in[2] | (hs & in[3]) | (hd & in[4]));
    endfunction

    function automatic logic dfrz(logic [5:0] v, logic [5:0] in, bit hs, bit hd);
        return v[1] & in[5] & ~afrz(v, in, hs, hd);
    endfunction

    function automatic logic [5:0] model_next(logic [5:0] v, logic [5:0] in, bit hs, bit hd);
        logic [5:0] n;
        logic a, d;
        a = afrz(v, in, hs, hd);
        d = dfrz(v, in, hs, hd);
        n[5] = a ? 1'b0 : v[4];
        n[4] = a ? v[4] : v[3];
        n[3] = a ? v[3] : v[2];
        n[2] = a ? v[2] : (d ? 1'b0 : v[1]);
        n[1] = (a | d) ? v[1] : v[0];
        n[0] = (a | d) ? v[0] : in[0];
        if (in[1]) n[2:0] = 3'b000;
        return n;
    endfunction

    function automatic string pick_tag(bit is_valid, int k, logic [5:0] v, logic [5:0] in, bit hs, bit hd);
        logic a, d;
        a = afrz(v, in, hs, hd);
        d = dfrz(v, in, hs, hd);
        if (is_valid && in[1] && k < 3) return "R10";
        if (!a && ((!hs && in[3]) || (!hd && in[4])) && v[4]) return "R8";
        if ((!v[4] && |in[4:2]) || (!v[1] && in[5])) return "R9";
        if (a && v[1] && in[5]) return "R6";
        if (a && k == 5) return "R4";
        if (a && is_valid && k < 5 && !v[k+1]) return "R7";
        if (a) return "R3";
        if (d) return "R5";
        return "R2";
    endfunction

    function automatic int first_diff(logic [5:0] x, logic [5:0] y);
        for (int i = 0; i < 6; i++) if (x[i] !== y[i]) return i;
        return 0;
    endfunction

    task automatic chk(string tag, string what, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // One cycle: check state, drive inputs, check controls, advance model.
    task automatic step(logic [5:0] in);
        logic [5:0] h;
        chk(pick_tag(1, first_diff(va, exp_a), pv_a, pin, 1, 0), "valid(a)", va, exp_a);
        chk(pick_tag(1, first_diff(vb, exp_b), pv_b, pin, 0, 1), "valid(b)", vb, exp_b);
        {d_hazard, a_div_busy, a_shift_busy, a_mem_busy, flush, issue_valid} = in;
        #1;
        h = afrz(exp_a, in, 1, 0) ? 6'b011111 : (dfrz(exp_a, in, 1, 0) ? 6'b000011 : 6'b0);
        chk(pick_tag(0, first_diff(adva, ~h), exp_a, in, 1, 0), "adv(a)", adva, ~h);
        chk(pick_tag(0, first_diff(buba, {afrz(exp_a,in,1,0),2'b0,dfrz(exp_a,in,1,0),2'b0}), exp_a, in, 1, 0),
            "bubble(a)", buba, {afrz(exp_a, in, 1, 0), 2'b00, dfrz(exp_a, in, 1, 0), 2'b00});
        h = afrz(exp_b, in, 0, 1) ? 6'b011111 : (dfrz(exp_b, in, 0, 1) ? 6'b000011 : 6'b0);
        chk(pick_tag(0, first_diff(advb, ~h), exp_b, in, 0, 1), "adv(b)", advb, ~h);
        chk(pick_tag(0, first_diff(bubb, {afrz(exp_b,in,0,1),2'b0,dfrz(exp_b,in,0,1),2'b0}), exp_b, in, 0, 1),
            "bubble(b)", bubb, {afrz(exp_b, in, 0, 1), 2'b00, dfrz(exp_b, in, 0, 1), 2'b00});
        pv_a = exp_a; pv_b = exp_b; pin = in;
        exp_a = model_next(exp_a, in, 1, 0);
        exp_b = model_next(exp_b, in, 0, 1);
        @(negedge clk);
    endtask

    // R1: reset clears occupancy and leaves controls idle
    task automatic do_reset();
        rst_n = 1'b0;
        {d_hazard, a_div_busy, a_shift_busy, a_mem_busy, flush, issue_valid} = 6'b000001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        {d_hazard, a_div_busy, a_shift_busy, a_mem_busy, flush, issue_valid} = '0;
        #1;
        chk("R1", "valid after reset(a)", va, 6'b0);
        chk("R1", "valid after reset(b)", vb, 6'b0);
        chk("R1", "adv after reset", adva, 6'b111111);
        chk("R1", "bubble after reset", buba, 6'b0);
        @(negedge clk);
        exp_a = '0; exp_b = '0; pv_a = '0; pv_b = '0; pin = '0;
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [5:0] in;
        @(negedge clk);
        do_reset();
        // every input combination from a full pipeline, applied twice
        for (int c = 0; c < 64; c++) begin
            for (int p = 0; p < 6; p++) step(6'b000001);
            step(c[5:0]);
            step(c[5:0]);
        end
        do_reset();
        // skewed pseudo-random sweep
        lfsr = 16'hACE1;
        for (int n = 0; n < 6000; n++) begin
            for (int r = 0; r < 8; r++)
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in[0] = lfsr[0] | lfsr[1];
            in[1] = &lfsr[5:2];
            in[2] = lfsr[6] & lfsr[7];
            in[3] = lfsr[8] & lfsr[9];
            in[4] = lfsr[10] & lfsr[11];
            in[5] = lfsr[12] & (lfsr[13] | lfsr[14]);
            if (n % 500 < 40) in[2] = 1'b1;  // long align freezes
            step(in);
            if (n == 3000) do_reset();
        end
        step(6'b0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule